// File: doc/BRIEF.md
# Optical Navigation Sensor Motion Report Reader

This block is the host side of a serial link to an optical navigation sensor. One start pulse makes it fetch a complete motion report in a single burst. It drops chip select and sends the burst register address. It then waits the mandatory address-to-data pause and clocks in seven report bytes back to back. The decoded fields are presented in parallel together with a one-cycle done strobe. Before it will accept another request, it releases chip select for the burst-exit interval.

The link is SPI mode 3, most significant bit first. SCLK idles high, MOSI changes on SCLK falling edges and MISO is sampled on SCLK rising edges. Every delay is derived from the `CLK_HZ` parameter and rounded up to whole clock cycles. The serial clock rate comes from `SCLK_HZ`.

Top module: `motion_burst_rd`

## Requirements
- R1: While reset is asserted and while idle, ncs_o=1, sclk_o=1, busy_o=0 and done_o=0.
- R2: The first byte shifted out on mosi_o after a start is BURST_ADDR (default 0x50), MSB first. MOSI changes on SCLK falling edges and MISO is sampled on SCLK rising edges.
- R3: At least 120 ns pass between ncs_o falling and the first sclk_o falling edge.
- R4: At least 75 µs pass between the eighth (last address) sclk_o rising edge and the first data-bit falling edge.
- R5: Exactly 56 data clocks follow the address. Consecutive data falling edges are spaced by exactly one SCLK period (CLK_HZ/SCLK_HZ cycles), so no gap is inserted between bytes.
- R6: Received bytes map in arrival order to status_o, delta_x_o, delta_y_o, squal_o, the shutter high byte, the shutter low byte and max_pix_o.
- R7: delta_x_o and delta_y_o are two's-complement signed. shutter_o = {fifth byte, sixth byte}.
- R8: After the last data byte ncs_o rises, and it stays high for at least 4 µs before it can fall again, even when start_i is held high.
- R9: A start_i pulse while busy_o=1, including during the exit interval, is ignored and does not cause another burst.
- R10: done_o is a single-cycle pulse in the cycle the report fields update. The fields hold their value between pulses.
- R11: busy_o goes high in the cycle after an accepted start and stays high until the exit interval ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one report fetch (accepted when idle) |
| busy_o | output | 1 | Transaction or exit interval in progress |
| done_o | output | 1 | One-cycle strobe: report fields updated |
| status_o | output | 8 | Motion status byte |
| delta_x_o | output | 8 | Signed X movement |
| delta_y_o | output | 8 | Signed Y movement |
| squal_o | output | 8 | Surface quality |
| shutter_o | output | 16 | Shutter value, high byte first received |
| max_pix_o | output | 8 | Maximum pixel value |
| ncs_o | output | 1 | Sensor chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data to sensor |
| miso_i | input | 1 | Serial data from sensor |

## Verification
busy_o is expected high at the first falling clock edge after the edge that samples start_i. The report fields and done_o are checked at the falling edge where done_o first reads high. The next falling edge must show done_o low and ncs_o high. The SCLK and chip-select timings are measured by a monitor that timestamps each ncs_o and sclk_o transition at falling system-clock edges. Each measured interval is compared against bounds the bench converts from nanoseconds. The ignored-request checks wait 300 cycles past the end of the exit interval before they count chip-select falls and done pulses, so that a wrongly accepted burst would already be visible.

// File: rtl/motion_burst_pkg.sv
package motion_burst_pkg;
  localparam int NUM_BYTES = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ADDR,
    ST_GAP,
    ST_DATA,
    ST_EXIT
  } mb_state_e;
endpackage

// File: rtl/mb_delay.sv
module mb_delay #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/mb_spi_byte.sv
module mb_spi_byte #(
  parameter int HALF = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       chain_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       byte_done_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic          active_q, hi_q;
  logic [CW-1:0] hcnt_q;
  logic [2:0]    bit_q;
  logic [7:0]    txs_q, rxs_q;

  logic half_end, last_bit;
  assign half_end    = (hcnt_q == CW'(HALF - 1));
  assign last_bit    = (bit_q == 3'd7);
  assign byte_done_o = active_q && hi_q && half_end && last_bit;
  assign rx_o        = rxs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      hi_q     <= 1'b1;
      sclk_o   <= 1'b1;
      mosi_o   <= 1'b1;
      hcnt_q   <= '0;
      bit_q    <= '0;
      txs_q    <= '0;
      rxs_q    <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        hi_q     <= 1'b0;
        sclk_o   <= 1'b0;
        mosi_o   <= tx_i[7];
        txs_q    <= {tx_i[6:0], 1'b0};
        bit_q    <= '0;
        hcnt_q   <= '0;
      end
    end else if (!half_end) begin
      hcnt_q <= hcnt_q + 1'b1;
    end else begin
      hcnt_q <= '0;
      if (!hi_q) begin
        // rising edge: sample
        hi_q   <= 1'b1;
        sclk_o <= 1'b1;
        rxs_q  <= {rxs_q[6:0], miso_i};
      end else if (!last_bit) begin
        hi_q   <= 1'b0;
        sclk_o <= 1'b0;
        mosi_o <= txs_q[7];
        txs_q  <= {txs_q[6:0], 1'b0};
        bit_q  <= bit_q + 1'b1;
      end else if (chain_i) begin
        // seamless next byte, no idle time
        hi_q   <= 1'b0;
        sclk_o <= 1'b0;
        mosi_o <= tx_i[7];
        txs_q  <= {tx_i[6:0], 1'b0};
        bit_q  <= '0;
      end else begin
        active_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/motion_burst_rd.sv
module motion_burst_rd
  import motion_burst_pkg::*;
#(
  parameter int         CLK_HZ     = 50_000_000,
  parameter int         SCLK_HZ    = 2_500_000,
  parameter logic [7:0] BURST_ADDR = 8'h50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [7:0]        status_o,
  output logic signed [7:0] delta_x_o,
  output logic signed [7:0] delta_y_o,
  output logic [7:0]        squal_o,
  output logic [15:0]       shutter_o,
  output logic [7:0]        max_pix_o,
  output logic              ncs_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int CLK_KHZ = CLK_HZ / 1000;
  localparam int HALF    = (CLK_HZ / (2 * SCLK_HZ) > 1) ? CLK_HZ / (2 * SCLK_HZ) : 2;
  localparam int T_CS    = (CLK_KHZ * 120) / 1_000_000 + 2;
  localparam int T_AD    = (CLK_KHZ * 75) / 1000 + 1;
  localparam int T_EXIT  = (CLK_KHZ * 4) / 1000 + 1;
  localparam int TW      = $clog2(T_AD + 1);
  localparam int IW      = $clog2(NUM_BYTES);

  mb_state_e state_q;
  logic [IW-1:0] idx_q;
  logic [NUM_BYTES-2:0][7:0] rep_q;

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_len;
  logic          sh_start, sh_chain, byte_done;
  logic [7:0]    sh_tx, sh_rx;
  logic          last_byte;

  assign last_byte = (idx_q == IW'(NUM_BYTES - 1));
  assign sh_tx     = (state_q == ST_SETUP) ? BURST_ADDR : 8'h00;
  assign sh_chain  = (state_q == ST_DATA) && !last_byte;

  always_comb begin
    tmr_load = 1'b0;
    tmr_len  = '0;
    sh_start = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start_i) begin tmr_load = 1'b1; tmr_len = TW'(T_CS - 1); end
      ST_SETUP: sh_start = tmr_zero;
      ST_ADDR:  if (byte_done) begin tmr_load = 1'b1; tmr_len = TW'(T_AD - 1); end
      ST_GAP:   sh_start = tmr_zero;
      ST_DATA:  if (byte_done && last_byte) begin tmr_load = 1'b1; tmr_len = TW'(T_EXIT - 1); end
      default: ;
    endcase
  end

  mb_delay #(.W(TW)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .zero_o (tmr_zero)
  );

  mb_spi_byte #(.HALF(HALF)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (sh_start),
    .chain_i     (sh_chain),
    .tx_i        (sh_tx),
    .miso_i      (miso_i),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o),
    .rx_o        (sh_rx),
    .byte_done_o (byte_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ncs_o     <= 1'b1;
      idx_q     <= '0;
      rep_q     <= '0;
      done_o    <= 1'b0;
      status_o  <= '0;
      delta_x_o <= '0;
      delta_y_o <= '0;
      squal_o   <= '0;
      shutter_o <= '0;
      max_pix_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SETUP;
          ncs_o   <= 1'b0;
        end
        ST_SETUP: if (tmr_zero) state_q <= ST_ADDR;
        ST_ADDR:  if (byte_done) state_q <= ST_GAP;
        ST_GAP: if (tmr_zero) begin
          state_q <= ST_DATA;
          idx_q   <= '0;
        end
        ST_DATA: if (byte_done) begin
          if (!last_byte) begin
            rep_q[idx_q] <= sh_rx;
            idx_q        <= idx_q + 1'b1;
          end else begin
            status_o  <= rep_q[0];
            delta_x_o <= $signed(rep_q[1]);
            delta_y_o <= $signed(rep_q[2]);
            squal_o   <= rep_q[3];
            shutter_o <= {rep_q[4], rep_q[5]};
            max_pix_o <= sh_rx;
            done_o    <= 1'b1;
            ncs_o     <= 1'b1;
            state_q   <= ST_EXIT;
          end
        end
        ST_EXIT: if (tmr_zero) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/motion_burst_rd_chk.sv
module motion_burst_rd_chk #(
  parameter int EXIT_CYC = 201
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              ncs_o,
  input logic              sclk_o,
  input logic signed [7:0] delta_x_o,
  input logic [15:0]       shutter_o
);
  localparam int HW = $clog2(EXIT_CYC + 2);

  logic [HW-1:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  hi_cnt_q <= HW'(EXIT_CYC);
    else if (!ncs_o)                              hi_cnt_q <= '0;
    else if (hi_cnt_q < HW'(EXIT_CYC))            hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  assert_idle_pins_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ncs_o && sclk_o));

  assert_sclk_needs_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ncs_o |-> sclk_o);

  assert_exit_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ncs_o) |-> (hi_cnt_q >= HW'(EXIT_CYC)));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_report_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(delta_x_o) && $stable(shutter_o)));

  assert_busy_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_done_in_burst_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
endmodule

bind motion_burst_rd motion_burst_rd_chk #(.EXIT_CYC(T_EXIT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .ncs_o     (ncs_o),
  .sclk_o    (sclk_o),
  .delta_x_o (delta_x_o),
  .shutter_o (shutter_o)
);

// File: tb/motion_burst_rd_tb.sv
module motion_burst_rd_tb_top;
  localparam int         CLK_PERIOD_NS = 20;
  localparam int         CLK_HZ        = 50_000_000;
  localparam int         SCLK_HZ       = 2_500_000;
  localparam logic [7:0] ADDR          = 8'h50;
  localparam int         SCLK_CYC      = CLK_HZ / SCLK_HZ;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, miso_i = 1'b1;
  logic busy_o, done_o, ncs_o, sclk_o, mosi_o;
  logic [7:0] status_o, squal_o, max_pix_o;
  logic signed [7:0] delta_x_o, delta_y_o;
  logic [15:0] shutter_o;

  motion_burst_rd #(.CLK_HZ(CLK_HZ), .SCLK_HZ(SCLK_HZ), .BURST_ADDR(ADDR)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .status_o(status_o), .delta_x_o(delta_x_o), .delta_y_o(delta_y_o), .squal_o(squal_o),
    .shutter_o(shutter_o), .max_pix_o(max_pix_o), .ncs_o(ncs_o), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .miso_i(miso_i)
  );

  always #(CLK_PERIOD_NS / 2) clk_i = ~clk_i;

  int n_checks = 0, n_fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // sensor model
  logic [55:0] rep_bits = '0;
  logic [7:0]  addr_cap = '0;
  int          sn_bit = 0;
  logic        sn_sclk_q = 1'b1;
  always @(sclk_o or ncs_o) begin
    if (ncs_o) sn_bit = 0;
    else if (sclk_o && !sn_sclk_q) begin
      if (sn_bit < 8) addr_cap = {addr_cap[6:0], mosi_o};
      sn_bit++;
    end else if (!sclk_o && sn_sclk_q && sn_bit >= 8 && sn_bit < 64)
      miso_i = rep_bits[55 - (sn_bit - 8)];
    sn_sclk_q = sclk_o;
  end

  // pin timing monitor
  longint cyc = 0;
  logic   p_ncs = 1'b1, p_sclk = 1'b1;
  int     rises = 0, falls = 0, n_ncs_fall = 0, n_done = 0;
  longint t_ncs_fall = 0, t_ncs_rise = 0, t_first_fall = 0, t_addr_end = 0, t_data_first = 0;
  longint last_fall = 0, min_dint = 0, max_dint = 0, min_exit = 1_000_000;
  bit     had_rise = 0;
  always @(negedge clk_i) begin
    cyc++;
    if (done_o) n_done++;
    if (p_ncs && !ncs_o) begin
      n_ncs_fall++;
      if (had_rise && (cyc - t_ncs_rise) < min_exit) min_exit = cyc - t_ncs_rise;
      rises = 0; falls = 0; t_ncs_fall = cyc;
    end
    if (!p_ncs && ncs_o) begin t_ncs_rise = cyc; had_rise = 1; end
    if (!ncs_o && p_sclk && !sclk_o) begin
      falls++;
      if (falls == 1) t_first_fall = cyc;
      if (falls == 9) begin t_data_first = cyc; min_dint = 1_000_000; max_dint = 0; end
      if (falls > 9) begin
        if (cyc - last_fall < min_dint) min_dint = cyc - last_fall;
        if (cyc - last_fall > max_dint) max_dint = cyc - last_fall;
      end
      last_fall = cyc;
    end
    if (!ncs_o && !p_sclk && sclk_o) begin
      rises++;
      if (rises == 8) t_addr_end = cyc;
    end
    p_ncs = ncs_o; p_sclk = sclk_o;
  end

  function automatic logic [7:0] rb(input logic [55:0] b, input int k);
    return b[55 - 8*k -: 8];
  endfunction
  function automatic longint exp_signed(input logic [7:0] v);
    return longint'($signed(v));
  endfunction

  task automatic wait_done();
    while (done_o !== 1'b1) @(negedge clk_i);
  endtask

  task automatic do_burst(input logic [55:0] b, input bit extra_starts);
    int nf0, nd0;
    rep_bits = b;
    nf0 = n_ncs_fall; nd0 = n_done;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    chk(busy_o == 1'b1, "R11 busy after start", longint'(busy_o), 1);
    if (extra_starts) begin
      repeat (1000) @(negedge clk_i);
      start_i = 1'b1; @(negedge clk_i) start_i = 1'b0;
    end
    wait_done();
    chk(status_o == rb(b, 0), "R6 status", status_o, rb(b, 0));
    chk(longint'(delta_x_o) == exp_signed(rb(b, 1)), "R7 delta_x", delta_x_o, exp_signed(rb(b, 1)));
    chk(longint'(delta_y_o) == exp_signed(rb(b, 2)), "R7 delta_y", delta_y_o, exp_signed(rb(b, 2)));
    chk(squal_o == rb(b, 3), "R6 squal", squal_o, rb(b, 3));
    chk(shutter_o == {rb(b, 4), rb(b, 5)}, "R7 shutter", shutter_o, {rb(b, 4), rb(b, 5)});
    chk(max_pix_o == rb(b, 6), "R6 max_pix", max_pix_o, rb(b, 6));
    @(negedge clk_i);
    chk(done_o == 1'b0, "R10 done single pulse", longint'(done_o), 0);
    chk(ncs_o == 1'b1 && busy_o == 1'b1, "R8 ncs released, exit busy", longint'({ncs_o, busy_o}), 3);
    if (extra_starts) begin
      start_i = 1'b1; @(negedge clk_i) start_i = 1'b0;
    end
    while (busy_o) @(negedge clk_i);
    repeat (300) @(negedge clk_i);
    chk(longint'(addr_cap) == longint'(ADDR), "R2 address byte", addr_cap, ADDR);
    chk((t_first_fall - t_ncs_fall) * CLK_PERIOD_NS >= 120, "R3 cs to sclk ns",
        (t_first_fall - t_ncs_fall) * CLK_PERIOD_NS, 120);
    chk((t_data_first - t_addr_end) * CLK_PERIOD_NS >= 75000, "R4 addr to data ns",
        (t_data_first - t_addr_end) * CLK_PERIOD_NS, 75000);
    chk(falls == 64 && rises == 64, "R5 clock count", falls, 64);
    chk(min_dint == SCLK_CYC && max_dint == SCLK_CYC, "R5 data spacing", max_dint, SCLK_CYC);
    chk(n_done - nd0 == 1, "R10 one done per burst", n_done - nd0, 1);
    if (extra_starts) begin
      chk(n_ncs_fall - nf0 == 1, "R9 ignored starts", n_ncs_fall - nf0, 1);
      chk(busy_o == 1'b0 && ncs_o == 1'b1, "R9 idle after", longint'(busy_o), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    repeat (5) @(negedge clk_i);
    chk(ncs_o == 1 && sclk_o == 1 && busy_o == 0 && done_o == 0, "R1 in reset",
        longint'({ncs_o, sclk_o, busy_o, done_o}), 4'b1100);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(ncs_o == 1 && sclk_o == 1 && busy_o == 0, "R1 idle", longint'({ncs_o, sclk_o, busy_o}), 3'b110);

    do_burst(56'h01_80_7F_A5_FF_00_3C, 1'b0);
    do_burst(56'hFE_7F_80_00_00_FF_C3, 1'b0);
    do_burst(56'h55_AA_55_AA_12_34_99, 1'b1);
    for (int i = 0; i < 5; i++)
      do_burst({$urandom(), $urandom()}[55:0], (i == 2));

    // start held high: ncs must still release for the exit time
    min_exit = 1_000_000;
    begin
      int nf0, nd0;
      nf0 = n_ncs_fall; nd0 = n_done;
      @(negedge clk_i) start_i = 1'b1;
      while (n_done - nd0 < 2) @(negedge clk_i);
      start_i = 1'b0;
      while (busy_o) @(negedge clk_i);
      repeat (20) @(negedge clk_i);
      chk(n_ncs_fall - nf0 >= 2, "R8 separate bursts", n_ncs_fall - nf0, 2);
      chk(min_exit * CLK_PERIOD_NS >= 4000, "R8 exit ns", min_exit * CLK_PERIOD_NS, 4000);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule